// File: doc/BRIEF.md
# Bit-Sliced Four-Bit Arithmetic Logic Unit

A purely combinational arithmetic logic unit for narrow datapaths. The word is split into identical one-bit slices. Each slice contains three parts:

- an arithmetic part: a full adder whose second input is first conditioned from the B bit;
- a logic part: a small bitwise function unit;
- a two-way choice between the two results.

Carries ripple from slice to slice. The external carry-in enters the least significant slice.

The top select bit chooses between arithmetic and logic. The two lower select bits steer the adder operand (zero, B, inverted B or all ones), or pick the bitwise function. With the carry-in this one adder covers these operations:

- transfer and increment;
- add and add-with-carry;
- subtract-with-borrow and subtract;
- decrement.

The carry flag and the signed overflow flag report on arithmetic results only.

Top module: `bsalu_top`

## Requirements
- R1: With sel_i[2]=0, the adder operand Y is chosen by sel_i[1:0] as follows: 00 gives zero, 01 gives B, 10 gives the bitwise inverse of B, and 11 gives all ones. The result g_o equals (A + Y + carry_i) modulo 16.
- R2: The named arithmetic operations follow from R1:
  - sel 000 with carry 0 passes A through;
  - sel 000 with carry 1 gives A+1;
  - sel 010 with carry 1 gives A-B;
  - sel 011 with carry 0 gives A-1.
- R3: In arithmetic mode, c_o equals bit 4 of the five-bit sum A + Y + carry_i, which is the carry out of the top slice.
- R4: In arithmetic mode, v_o is the carry into the top slice XOR the carry out of it. It is 1 exactly when A and Y share bit 3 and the result's bit 3 differs from A's.
- R5: With sel_i[2]=1, sel_i[1:0] picks the bitwise function: 00 AND, 01 OR, 10 XOR, 11 NOT A. carry_i has no effect on g_o.
- R6: With sel_i[2]=1, c_o and v_o are both 0.
- R7: With A=3, B=7 and sel 100, g_o is 3.
- R8: All outputs are a combinational function of the present inputs; a change of inputs shows on the outputs without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First operand A |
| b_i | input | 4 | Second operand B |
| sel_i | input | 3 | Function select: bit 2 picks logic, bits 1:0 pick the operand or the function |
| carry_i | input | 1 | Carry into the least significant slice |
| g_o | output | 4 | Result |
| c_o | output | 1 | Carry out of the top slice (0 in logic mode) |
| v_o | output | 1 | Signed overflow (0 in logic mode) |

## Verification
Every slice produces an arithmetic result and a logic result at the same time. The top select must let only one of them through, and in logic mode it must also silence both flags even when the idle adder is carrying out or overflowing.

The bench provokes this collision by sweeping every operand pair with both carry-in values in each logic function. Many of these pairs make the adder carry or overflow. The bench requires g_o to match the bitwise result and c_o and v_o to read 0.

Operand pairs that overflow are also run in each arithmetic mode, and the flags are compared against a five-bit sum and a sign rule that the bench computes separately.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

  // Operand conditioning codes for the adder's second input.
  typedef enum logic [1:0] {
    YSEL_ZERO = 2'b00,
    YSEL_B    = 2'b01,
    YSEL_NOTB = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;

  // Bitwise function codes.
  typedef enum logic [1:0] {
    LOP_AND  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_XOR  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;

  // Adder operand for one bit, derived from the B bit.
  function automatic logic cond_operand(input logic b, input logic [1:0] sel);
    logic y;
    case (ysel_e'(sel))
      YSEL_ZERO: y = 1'b0;
      YSEL_B:    y = b;
      YSEL_NOTB: y = ~b;
      default:   y = 1'b1;
    endcase
    return y;
  endfunction

  // One-bit full adder: returns {carry_out, sum}.
  function automatic logic [1:0] full_add(input logic a, input logic y, input logic ci);
    logic s;
    logic co;
    s  = a ^ y ^ ci;
    co = (a & y) | (ci & (a ^ y));
    return {co, s};
  endfunction

  // One-bit bitwise function.
  function automatic logic bit_func(input logic a, input logic b, input logic [1:0] op);
    logic r;
    case (lop_e'(op))
      LOP_AND: r = a & b;
      LOP_OR:  r = a | b;
      LOP_XOR: r = a ^ b;
      default: r = ~a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bsalu_arith_bit.sv
module bsalu_arith_bit
  import bsalu_pkg::*;
#(
  parameter bit IS_MSB = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] ysel_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       cout_o
);

  logic       y_bit;
  logic [1:0] add_res;
  logic       ovf_local;

  always_comb begin
    y_bit     = cond_operand(b_i, ysel_i);
    add_res   = full_add(a_i, y_bit, cin_i);
    sum_o     = add_res[0];
    cout_o    = add_res[1];
    ovf_local = IS_MSB ? (cin_i ^ add_res[1]) : 1'b0;

    // R1: a zero operand cannot carry out unless both A and carry-in are 1
    p_zero_operand_r1 : assert (!(ysel_i == YSEL_ZERO && add_res[1] && !(a_i && cin_i)))
      else $error("p_zero_operand_r1");

    // R1: an all-ones operand carries out whenever A or carry-in is 1
    p_ones_operand_r1 : assert (!(ysel_i == YSEL_ONES && (a_i || cin_i) && !add_res[1]))
      else $error("p_ones_operand_r1");

    // R4: overflow only when operand signs agree and the result sign departs
    p_no_overflow_r4 : assert (!ovf_local || ((a_i == y_bit) && (add_res[0] != a_i)))
      else $error("p_no_overflow_r4");
  end

endmodule

// File: rtl/bsalu_logic_bit.sv
module bsalu_logic_bit
  import bsalu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] op_i,
  output logic       res_o
);

  logic r;

  always_comb begin
    r     = bit_func(a_i, b_i, op_i);
    res_o = r;

    // R5: an AND result of 1 needs both operand bits set
    p_and_needs_both_r5 : assert (!(op_i == LOP_AND && r && !(a_i && b_i)))
      else $error("p_and_needs_both_r5");

    // R5: an OR result of 0 needs both operand bits clear
    p_or_needs_none_r5 : assert (!(op_i == LOP_OR && !r && (a_i || b_i)))
      else $error("p_or_needs_none_r5");

    // R5: the inversion never agrees with A
    p_not_differs_r5 : assert (!(op_i == LOP_NOTA && (r == a_i)))
      else $error("p_not_differs_r5");
  end

endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice #(
  parameter bit IS_MSB = 1'b0
) (
  input  logic       a_i,
  input  logic       b_i,
  input  logic [2:0] sel_i,
  input  logic       cin_i,
  output logic       g_o,
  output logic       cout_o
);

  logic arith_bit;
  logic logic_bit;

  bsalu_arith_bit #(.IS_MSB(IS_MSB)) u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .ysel_i (sel_i[1:0]),
    .cin_i  (cin_i),
    .sum_o  (arith_bit),
    .cout_o (cout_o)
  );

  bsalu_logic_bit u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (sel_i[1:0]),
    .res_o (logic_bit)
  );

  // Top select bit chooses the logic result.
  always_comb g_o = sel_i[2] ? logic_bit : arith_bit;

endmodule

// File: rtl/bsalu_top.sv
module bsalu_top #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       sel_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] g_o,
  output logic             c_o,
  output logic             v_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] carry_chain;
  logic           logic_mode;

  assign carry_chain[0] = carry_i;
  assign logic_mode     = sel_i[2];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bsalu_slice #(.IS_MSB(i == MSB)) u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .sel_i  (sel_i),
      .cin_i  (carry_chain[i]),
      .g_o    (g_o[i]),
      .cout_o (carry_chain[i+1])
    );
  end

  // Flags report arithmetic results only.
  assign c_o = ~logic_mode & carry_chain[WIDTH];
  assign v_o = ~logic_mode & (carry_chain[WIDTH] ^ carry_chain[MSB]);

endmodule

// File: tb/bsalu_top_bench.sv
module bsalu_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 50000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a, b;
  logic [2:0] sel;
  logic       cin;
  logic [3:0] g;
  logic       c, v;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsalu_top u_bsalu_top (
    .a_i(a), .b_i(b), .sel_i(sel), .carry_i(cin),
    .g_o(g), .c_o(c), .v_o(v)
  );

  // Bench model: arithmetic operand.
  function automatic int model_y(int bv, int s);
    case (s & 3)
      0:       return 0;
      1:       return bv;
      2:       return 15 - bv;
      default: return 15;
    endcase
  endfunction

  // Bench model: {c, v, g[3:0]} as a 6-bit value.
  function automatic int model(int av, int bv, int s, int ci);
    int y, tot, gg, cc, vv;
    if (s >= 4) begin
      case (s & 3)
        0:       gg = av & bv;
        1:       gg = av | bv;
        2:       gg = av ^ bv;
        default: gg = 15 - av;
      endcase
      return gg;
    end
    y   = model_y(bv, s);
    tot = av + y + ci;
    gg  = tot % 16;
    cc  = tot / 16;
    vv  = ((av >= 8) == (y >= 8)) && ((gg >= 8) != (av >= 8)) ? 1 : 0;
    return (vv << 5) | (cc << 4) | gg;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d sel=%0d cin=%0d got v,c,g=%0h expected %0h",
               tag, a, b, sel, cin, got, exp);
    end
  endtask

  function automatic string tag_for(int s, int av, int bv, int ci);
    int r;
    if (s >= 4) return ((s & 1) == 0) ? "R5/R6" : "R6/R5";
    r = model(av, bv, s, ci);
    if (r >= 32) return "R4";
    if (r >= 16) return "R3";
    return "R1";
  endfunction

  task automatic apply(input int av, input int bv, input int s, input int ci, input string tag);
    @(posedge clk);
    a = 4'(av); b = 4'(bv); sel = 3'(s); cin = 1'(ci);
    @(negedge clk);
    check(tag, {26'd0, v, c, g}, model(av, bv, s, ci));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WDOG_LIMIT && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; sel = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state with all-zero inputs: transfer of zero, no flags (R1)
    check("R1 idle", {26'd0, v, c, g}, 0);

    // R7: worked AND example
    apply(3, 7, 4, 0, "R7");
    check("R7 g", int'(g), 3);

    // R2: named operations
    apply(9, 5, 0, 0, "R2 transfer");
    apply(15, 5, 0, 1, "R2 increment wrap");
    apply(9, 5, 2, 1, "R2 subtract");
    apply(2, 5, 2, 1, "R2 subtract borrow");
    apply(0, 5, 3, 0, "R2 decrement wrap");
    apply(8, 0, 3, 0, "R2 decrement overflow");

    // R3/R4 corners: signed and unsigned overflow
    apply(7, 1, 1, 0, "R4 pos overflow");
    apply(8, 8, 1, 0, "R4 neg overflow carry");
    apply(8, 1, 2, 1, "R4 sub overflow");
    apply(15, 15, 1, 1, "R3 max carry");

    // R5/R6: logic with a heavily carrying adder; carry-in ignored
    apply(15, 15, 4, 1, "R6 and flags");
    apply(8, 8, 5, 1, "R6 or flags");
    apply(7, 1, 6, 0, "R5 xor");
    apply(10, 3, 7, 1, "R5 not");

    // R8: inputs change mid-cycle, outputs follow without an edge
    @(negedge clk);
    a = 4'd6; b = 4'd5; sel = 3'd1; cin = 1'b0;
    #1;
    check("R8 comb", {26'd0, v, c, g}, model(6, 5, 1, 0));

    // Exhaustive sweep: every A, B, select and carry-in
    for (int s = 0; s < 8; s++)
      for (int ci = 0; ci < 2; ci++)
        for (int av = 0; av < 16; av++)
          for (int bv = 0; bv < 16; bv++)
            apply(av, bv, s, ci, tag_for(s, av, bv, ci));

    // Constrained random mix, fixed seed
    begin
      int unsigned seed_v;
      seed_v = $urandom(32'h5A1C);
      for (int k = 0; k < 1500; k++) begin
        int av, bv, s, ci;
        av = int'($urandom % 16);
        bv = int'($urandom % 16);
        s  = int'($urandom % 8);
        ci = int'($urandom % 2);
        // bias toward operands near the sign boundary
        if (k % 4 == 0) av = 7 + (av & 1);
        apply(av, bv, s, ci, tag_for(s, av, bv, ci));
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule